// File: doc/BRIEF.md
# Clocked Serial Transmit Channel

This block sends bytes over a synchronous serial link: a data line plus a shift clock that it drives itself. A processor or a DMA engine writes a byte into a one-entry holding register. When the channel is enabled and the shifter is free, the byte moves into the shifter. The shifter then sends eight bits, least significant first, with the shift clock running at one quarter of the system clock. A byte that is already waiting when the current frame ends is loaded on that same cycle. Consecutive frames therefore follow each other with no idle gap, and the busy status stays high for the whole train.

Each time a byte moves from the holding register into the shifter, the channel emits a one-cycle DMA request. It emits another when the enable goes from low to high. This lets a DMA engine refill the holding register. The same events raise a one-cycle "room available" interrupt, but only while that interrupt is unmasked. A write that replaces a byte not yet sent sets a sticky overrun flag, which is cleared by a separate strobe. Dropping the enable stops the channel: any frame in progress is abandoned and the waiting byte is discarded.

Top module: `clkser_tx`

## Requirements
- R1: A frame is 8 bits sent LSB first. The shift clock idles high and each period is 4 system cycles, low for the first 2 and high for the last 2. The data line changes only when the shift clock falls. While no frame is being sent, both lines are high.
- R2: On the clock edge where a byte moves into the shifter, `busy` becomes 1. For a frame with no byte waiting behind it, `busy` returns to 0 by itself once the eighth bit period has ended.
- R3: If a byte is waiting when a frame's last bit period ends, the next frame starts on the very next cycle. `busy` stays 1 between the frames and falls only after the final frame of the train.
- R4: A byte moves into the shifter only if all three hold: `tx_en` is 1, the holding register is full, and the shifter is idle or in the last cycle of its final bit.
- R5: While `irq_en` is 1, `irq` pulses for one cycle, one cycle after each load into the shifter and one cycle after `tx_en` rises. While `irq_en` is 0, `irq` stays low.
- R6: `dreq` pulses for one cycle, one cycle after each load into the shifter and one cycle after `tx_en` rises, whatever the value of `irq_en`.
- R7: Each load and each rising edge of `tx_en` produces exactly one pulse on each output that pulses for it.
- R8: A write while the holding register is full, and not on a cycle where the held byte moves into the shifter, replaces the held byte and sets `ovr`. `ovr` stays set until `ovr_clr` is pulsed; if a new overrun happens on the same cycle as the clear, `ovr` stays set.
- R9: While `tx_en` is 0, all of the following hold: any frame in progress is abandoned, both lines are high, `busy` is 0, the holding register is empty, and writes are ignored.
- R10: After reset both lines are high, and `busy`, `ovr`, `irq` and `dreq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| irq_en | input | 1 | Unmasks the room-available interrupt |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| ovr_clr | input | 1 | Clears the overrun flag |
| sclk | output | 1 | Shift clock, idles high |
| sdata | output | 1 | Serial data, idles high |
| busy | output | 1 | Transmit status |
| ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Room-available interrupt pulse |
| dreq | output | 1 | DMA transfer request pulse |

## Verification
The hardest case to reach from the ports is a write that lands on the exact cycle the held byte moves into the shifter. This write must not count as an overrun. The stimulus reaches it with two writes on back-to-back cycles while the shifter is idle: the second write coincides with the load of the first byte. A third write is then issued during the frame to produce a real overrun. The chained-frame case, where a byte waits until the last cycle of a frame, is produced by writing during an active frame. In both cases a cycle-accurate behavioural model tracks the state. The bits sent are also collected on the rising shift-clock edges and compared against the bytes the model expects to complete.

// File: rtl/clkser_pkg.sv
package clkser_pkg;
  // Shift clock is low for the first half of a bit period, high for the second.
  function automatic logic sclk_level(input int phase, input int div);
    return (phase >= div / 2);
  endfunction

  // True on the final system cycle of the final bit of a frame.
  function automatic logic frame_end(input int phase, input int bitn,
                                     input int div, input int dw);
    return (phase == div - 1) && (bitn == dw - 1);
  endfunction
endpackage

// File: rtl/clkser_buf.sv
module clkser_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr,
  input  logic [DW-1:0] wd,
  input  logic          take,
  input  logic          clr,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          ovr
);
  logic ovr_set;
  assign ovr_set = en && wr && full && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (wr) begin
      full <= 1'b1;
      data <= wd;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (ovr_set) ovr <= 1'b1;
    else if (clr)     ovr <= 1'b0;
  end
endmodule

// File: rtl/clkser_shift.sv
module clkser_shift
  import clkser_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  output logic          active,
  output logic          fin,
  output logic          sclk,
  output logic          sdata
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;

  assign fin   = active && frame_end(int'(phase), int'(bitn), DIV, DW);
  assign sclk  = !active || sclk_level(int'(phase), DIV);
  assign sdata = !active || shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
      bitn   <= '0;
      shreg  <= '0;
    end else if (!en) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      phase  <= '0;
      bitn   <= '0;
      shreg  <= ld_data;
    end else if (active) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        if (fin) begin
          active <= 1'b0;
        end else begin
          bitn  <= bitn + 1'b1;
          shreg <= shreg >> 1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkser_evt.sv
module clkser_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mask_en,
  input  logic hand,
  output logic rise,
  output logic irq,
  output logic dreq
);
  logic en_q;
  assign rise = en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      irq  <= 1'b0;
      dreq <= 1'b0;
    end else begin
      en_q <= en;
      dreq <= hand || rise;
      irq  <= mask_en && (hand || rise);
    end
  end
endmodule

// File: rtl/clkser_tx.sv
module clkser_tx #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          irq_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          ovr_clr,
  output logic          sclk,
  output logic          sdata,
  output logic          busy,
  output logic          ovr,
  output logic          irq,
  output logic          dreq
);
  logic          buf_full;
  logic [DW-1:0] buf_data;
  logic          fin_w;
  logic          hand_w;
  logic          rise_w;

  // Handoff: enabled, byte waiting, shifter free or finishing.
  assign hand_w = tx_en && buf_full && (!busy || fin_w);

  clkser_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wr(wr_stb), .wd(wr_data),
    .take(hand_w), .clr(ovr_clr), .full(buf_full), .data(buf_data), .ovr(ovr)
  );

  clkser_shift #(.DW(DW), .DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .load(hand_w), .ld_data(buf_data),
    .active(busy), .fin(fin_w), .sclk(sclk), .sdata(sdata)
  );

  clkser_evt u_evt (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .mask_en(irq_en), .hand(hand_w),
    .rise(rise_w), .irq(irq), .dreq(dreq)
  );
endmodule

// File: rtl/clkser_tx_chk.sv
module clkser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic ovr_clr,
  input logic sclk,
  input logic sdata,
  input logic busy,
  input logic ovr,
  input logic irq,
  input logic dreq,
  input logic hand_w,
  input logic rise_w
);
  // R6
  dreq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> $past(hand_w || rise_w));
  // R5
  irq_with_dreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> dreq);
  // R2
  busy_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_w |=> busy);
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy && sclk && sdata));
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && sdata));
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);
endmodule

bind clkser_tx clkser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ovr_clr(ovr_clr),
  .sclk(sclk), .sdata(sdata), .busy(busy), .ovr(ovr), .irq(irq),
  .dreq(dreq), .hand_w(hand_w), .rise_w(rise_w)
);

// File: tb/test_clkser_tx.sv
module test_clkser_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ovr_clr = 1'b0;
  logic       sclk, sdata, busy, ovr, irq, dreq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkser_tx i_clkser_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
    .wr_stb(wr_stb), .wr_data(wr_data), .ovr_clr(ovr_clr),
    .sclk(sclk), .sdata(sdata), .busy(busy), .ovr(ovr), .irq(irq), .dreq(dreq)
  );

  // Behavioural reference model
  bit         m_busy, m_ovr, m_enq, m_irq, m_dreq;
  int         m_tick, m_pos;
  logic [7:0] m_frame;
  logic [7:0] m_hold[$];
  logic [7:0] m_sent[$];
  logic [7:0] got[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ovr = 0; m_enq = 0; m_irq = 0; m_dreq = 0;
      m_tick = 0; m_pos = 0; m_hold.delete();
    end else begin
      bit fin, hand, rise, oset;
      fin  = m_busy && m_tick == 3 && m_pos == 7;
      hand = tx_en && m_hold.size() != 0 && (!m_busy || fin);
      rise = tx_en && !m_enq;
      m_dreq = hand || rise;
      m_irq  = irq_en && (hand || rise);
      if (fin) m_sent.push_back(m_frame);
      if (!tx_en) m_busy = 0;
      else if (hand) begin
        m_busy = 1; m_frame = m_hold[0]; m_tick = 0; m_pos = 0;
      end else if (m_busy) begin
        if (m_tick == 3) begin
          if (m_pos == 7) m_busy = 0;
          else begin m_pos++; m_tick = 0; end
        end else m_tick++;
      end
      oset = 0;
      if (!tx_en) m_hold.delete();
      else begin
        if (hand) void'(m_hold.pop_front());
        if (wr_stb) begin
          if (m_hold.size() != 0) oset = 1;
          m_hold.delete();
          m_hold.push_back(wr_data);
        end
      end
      if (oset) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
      m_enq = tx_en;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  int         capn = 0;
  logic [7:0] cap;
  logic       prev_sclk = 1'b1;
  always @(negedge clk) begin
    logic esclk, esd;
    esclk = !m_busy || m_tick >= 2;
    esd   = !m_busy || m_frame[m_pos];
    chk("R1 sclk", sclk, esclk);
    chk("R1 sdata", sdata, esd);
    chk("R2/R3 busy", busy, m_busy);
    chk("R8 ovr", ovr, m_ovr);
    chk("R5 irq", irq, m_irq);
    chk("R6 dreq", dreq, m_dreq);
    if (!busy) capn = 0;
    else if (!prev_sclk && sclk) begin
      cap = {sdata, cap[7:1]};
      capn++;
      if (capn == 8) begin got.push_back(cap); capn = 0; end
    end
    prev_sclk = sclk;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] b);
    wr_stb = 1'b1; wr_data = b;
    cyc(1);
    wr_stb = 1'b0;
  endtask

  initial begin
    int nirq, ndreq;
    cyc(3);
    // R10: reset state
    chk("R10 reset sclk", sclk, 1'b1);
    chk("R10 reset sdata", sdata, 1'b1);
    chk("R10 reset busy", busy, 1'b0);
    chk("R10 reset ovr", ovr, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    irq_en = 1'b1; tx_en = 1'b1;
    cyc(3);                       // R5/R6/R7 enable-rise pulses
    wr(8'hA5);                    // R2 single frame
    cyc(45);
    chk("R2 busy cleared after single frame", busy, 1'b0);
    wr(8'h3C); wr(8'hC3);         // R8 second write coincides with handoff
    chk("R8 no overrun on handoff write", ovr, 1'b0);
    cyc(6);
    wr(8'h5A);                    // R8 real overrun, R3 chaining
    chk("R8 overrun set", ovr, 1'b1);
    cyc(80);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk("R8 overrun cleared", ovr, 1'b0);
    irq_en = 1'b0;                // R5 masked, R6 still pulses
    nirq = 0; ndreq = 0;
    fork
      begin wr(8'h0F); wr(8'hF0); end
      repeat (80) begin @(negedge clk); nirq += irq; ndreq += dreq; end
    join
    chk("R5 masked irq silent", nirq == 0, 1'b1);
    chk("R6 dreq count", ndreq == 2, 1'b1);
    irq_en = 1'b1;
    wr(8'hFF); cyc(12);
    tx_en = 1'b0;                 // R9 abort
    wr(8'h11);
    cyc(4);
    chk("R9 abort busy", busy, 1'b0);
    tx_en = 1'b1;
    cyc(40);
    chk("R9 write while disabled ignored", busy, 1'b0);
    wr(8'h81);                    // R4 handoff after re-enable
    cyc(45);
    // R1/R3 serial content of completed frames
    chk("R1 frame count", got.size() == m_sent.size(), 1'b1);
    foreach (got[i]) chk("R1 R3 frame bits", got[i] == m_sent[i], 1'b1);
    chk("R3 frame total", m_sent.size() == 6, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule